// File: doc/BRIEF.md
# Packed Column Range Filter

This block walks a dictionary-compressed column in which every row is a fixed-width integer code and the codes are laid end to end inside 64-bit words. It pulls each code out of the word stream, including codes whose bits are split between two consecutive words. It tests every code against a range whose lower bound is inclusive and whose upper bound is exclusive. It reports the outcome in two forms: a hit bitmap in 32-bit words, and a list of the row numbers that matched.

Software or a fetch engine writes the code width, the row count and the two bounds, and then pulses `start`. The packed words are streamed in with a valid/ready handshake. The block consumes exactly as many words as the rows occupy. It decodes one row per clock while both result streams keep up, and it stalls its input whenever a result stream is blocked. Each result stream marks its final beat with a last flag, so a scan is complete when both flags have been seen.

Top module: `colscan_filter`

## Requirements
- R1: Codes are packed least significant bit first with no padding. Row n (counting from 1) occupies stream bits (n-1)*W up to n*W-1, where stream bit k is bit k mod 64 of input word k div 64. A code that spans two words takes its low part from the top of the earlier word.
- R2: A row matches exactly when lo <= code and code < hi, compared as unsigned 32-bit numbers.
- R3: When lo >= hi, no row matches, and the full all-zero bitmap is still emitted.
- R4: Bitmap word j carries row 32*j+i+1 in bit i. The last word is zero above the final row and is the only word with `hv_last` set.
- R5: The row-ID stream gives the number of every matching row in ascending order, with the first row numbered 1.
- R6: If the final row matches, its ID beat carries `id_last`. Otherwise one extra beat with ID 0 and `id_last` set closes the stream.
- R7: A scan accepts exactly ceil(rows*W/64) input words. Bits of the final word beyond the last row are never compared.
- R8: Every width from 1 to 32 is decoded. Width, row count and bounds are sampled at start, so changing them during a scan has no effect on it.
- R9: `start` is ignored while a scan runs, when the row count is zero, or when the width is outside 1..32. An ignored start leaves `busy` and `s_ready` low and produces no output.
- R10: A result beat that is valid but not accepted holds its data and flag until it is taken. Backpressure loses no beat.
- R11: With input always valid and both outputs always ready, `busy` stays high for exactly rows+1 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begins a scan with the current configuration |
| cfg_width | input | 6 | Code width in bits, 1..32 |
| cfg_rows | input | 32 | Number of rows to scan |
| cfg_lo | input | 32 | Inclusive lower bound |
| cfg_hi | input | 32 | Exclusive upper bound |
| busy | output | 1 | A scan is in progress |
| s_valid | input | 1 | Packed input word valid |
| s_ready | output | 1 | Block accepts the input word |
| s_data | input | 64 | Packed input word |
| hv_valid | output | 1 | Bitmap word valid |
| hv_ready | input | 1 | Bitmap consumer accepts |
| hv_data | output | 32 | Bitmap word |
| hv_last | output | 1 | Final bitmap word of the scan |
| id_valid | output | 1 | Row ID valid |
| id_ready | input | 1 | Row ID consumer accepts |
| id_data | output | 32 | Matching row number, or 0 as end marker |
| id_last | output | 1 | Final ID beat of the scan |

## Verification
The bench aims at the points where an unpacker slips. It uses 15-, 13- and 7-bit widths so that codes straddle words, and widths 1 and 32 as the extremes. A design that stitched a straddling code wrongly would report hits on the wrong rows. The bench places codes at lo-1, lo, hi-1 and hi: an off-by-one bound would add or drop exactly those rows. It also fills the unused tail of the final word with ones, so a block that kept decoding past the row count would emit extra IDs or set pad bits. Random stalls on all three streams expose lost or repeated beats. Starts that should be ignored, including one issued mid-scan with a different width, would corrupt a running scan or launch a bogus one.

// File: rtl/colscan_filter.sv
module colscan_filter #(
  parameter int WORD_W   = 64,
  parameter int CODE_MAX = 32,
  parameter int ROW_W    = 32,
  parameter int VEC_W    = 32,
  localparam int WID_W   = $clog2(CODE_MAX + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic [WID_W-1:0]    cfg_width,
  input  logic [ROW_W-1:0]    cfg_rows,
  input  logic [CODE_MAX-1:0] cfg_lo,
  input  logic [CODE_MAX-1:0] cfg_hi,
  output logic                busy,
  input  logic                s_valid,
  output logic                s_ready,
  input  logic [WORD_W-1:0]   s_data,
  output logic                hv_valid,
  input  logic                hv_ready,
  output logic [VEC_W-1:0]    hv_data,
  output logic                hv_last,
  output logic                id_valid,
  input  logic                id_ready,
  output logic [ROW_W-1:0]    id_data,
  output logic                id_last
);
  localparam int BUF_W  = 2 * WORD_W;
  localparam int CNT_W  = $clog2(BUF_W + 1);
  localparam int POS_W  = $clog2(VEC_W);
  localparam int WCNT_W = ROW_W + WID_W;

  logic [WID_W-1:0]    w_q;
  logic [ROW_W-1:0]    rows_q, row_q;
  logic [CODE_MAX-1:0] lo_q, hi_q;
  logic [WCNT_W-1:0]   words_left;
  logic [BUF_W-1:0]    bits_q;
  logic [CNT_W-1:0]    cnt_q;
  logic [VEC_W-1:0]    acc_q;
  logic [POS_W-1:0]    pos_q;

  logic                cfg_ok, go, out_free, take, fire, last_row, hit, vec_full;
  logic [CNT_W-1:0]    cnt_rest;
  logic [CODE_MAX-1:0] mask, code;
  logic [WCNT_W-1:0]   need_bits, words_need;
  logic [BUF_W-1:0]    bits_nxt;

  assign cfg_ok   = (cfg_width != '0) && (cfg_width <= WID_W'(CODE_MAX)) && (cfg_rows != '0);
  assign go       = start && !busy && cfg_ok;
  assign out_free = (!hv_valid || hv_ready) && (!id_valid || id_ready);
  assign take     = busy && (cnt_q >= CNT_W'(w_q)) && out_free;
  assign last_row = (row_q == rows_q);
  assign vec_full = (pos_q == POS_W'(VEC_W - 1));

  assign cnt_rest = cnt_q - (take ? CNT_W'(w_q) : '0);
  assign s_ready  = busy && (words_left != '0) && (cnt_rest <= CNT_W'(WORD_W));
  assign fire     = s_valid && s_ready;

  assign mask = (w_q >= WID_W'(CODE_MAX)) ? '1 : ((CODE_MAX'(1) << w_q) - CODE_MAX'(1));
  assign code = bits_q[CODE_MAX-1:0] & mask;
  assign hit  = (code >= lo_q) && (code < hi_q);

  assign bits_nxt = (bits_q >> (take ? w_q : '0))
                  | (fire ? (BUF_W'(s_data) << cnt_rest) : '0);

  assign need_bits  = WCNT_W'(cfg_rows) * WCNT_W'(cfg_width);
  assign words_need = (need_bits + WCNT_W'(WORD_W - 1)) / WCNT_W'(WORD_W);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy       <= 1'b0;
      w_q        <= '0;
      rows_q     <= '0;
      row_q      <= '0;
      lo_q       <= '0;
      hi_q       <= '0;
      words_left <= '0;
      bits_q     <= '0;
      cnt_q      <= '0;
      acc_q      <= '0;
      pos_q      <= '0;
    end else if (go) begin
      busy       <= 1'b1;
      w_q        <= cfg_width;
      rows_q     <= cfg_rows;
      lo_q       <= cfg_lo;
      hi_q       <= cfg_hi;
      row_q      <= ROW_W'(1);
      words_left <= words_need;
      bits_q     <= '0;
      cnt_q      <= '0;
      acc_q      <= '0;
      pos_q      <= '0;
    end else if (busy) begin
      bits_q <= bits_nxt;
      cnt_q  <= cnt_rest + (fire ? CNT_W'(WORD_W) : '0);
      if (fire) words_left <= words_left - WCNT_W'(1);
      if (take) begin
        row_q <= row_q + ROW_W'(1);
        if (vec_full || last_row) begin
          acc_q <= '0;
          pos_q <= '0;
        end else begin
          acc_q <= acc_q | (VEC_W'(hit) << pos_q);
          pos_q <= pos_q + POS_W'(1);
        end
        if (last_row) begin
          busy   <= 1'b0;
          bits_q <= '0;
          cnt_q  <= '0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hv_valid <= 1'b0;
      hv_data  <= '0;
      hv_last  <= 1'b0;
      id_valid <= 1'b0;
      id_data  <= '0;
      id_last  <= 1'b0;
    end else begin
      if (take && (vec_full || last_row)) begin
        hv_valid <= 1'b1;
        hv_data  <= acc_q | (VEC_W'(hit) << pos_q);
        hv_last  <= last_row;
      end else if (hv_ready) begin
        hv_valid <= 1'b0;
      end
      if (take && (hit || last_row)) begin
        id_valid <= 1'b1;
        id_data  <= hit ? row_q : '0;
        id_last  <= last_row;
      end else if (id_ready) begin
        id_valid <= 1'b0;
      end
    end
  end

  a_r10_hv_hold: assert property (@(posedge clk) disable iff (!rst_n)
    hv_valid && !hv_ready |=> hv_valid && $stable(hv_data) && $stable(hv_last));

  a_r10_id_hold: assert property (@(posedge clk) disable iff (!rst_n)
    id_valid && !id_ready |=> id_valid && $stable(id_data) && $stable(id_last));

  a_r6_zero_id_closes: assert property (@(posedge clk) disable iff (!rst_n)
    id_valid && (id_data == '0) |-> id_last);

  a_r9_zero_rows_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && start && (cfg_rows == '0) |=> !busy);

  a_r1_buffer_bound: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(BUF_W));
endmodule

// File: tb/colscan_filter_bench.sv
`timescale 1ns/1ps
module colscan_filter_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [5:0]  cfg_width = '0;
  logic [31:0] cfg_rows = '0, cfg_lo = '0, cfg_hi = '0;
  logic        busy, s_ready, hv_valid, hv_last, id_valid, id_last;
  logic        s_valid = 1'b0, hv_ready = 1'b0, id_ready = 1'b0;
  logic [63:0] s_data = '0;
  logic [31:0] hv_data, id_data;

  colscan_filter u_colscan_filter (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg_width(cfg_width),
    .cfg_rows(cfg_rows), .cfg_lo(cfg_lo), .cfg_hi(cfg_hi), .busy(busy),
    .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data),
    .hv_valid(hv_valid), .hv_ready(hv_ready), .hv_data(hv_data), .hv_last(hv_last),
    .id_valid(id_valid), .id_ready(id_ready), .id_data(id_data), .id_last(id_last));

  always #4 clk = ~clk;

  int          n_chk = 0, n_bad = 0;
  int          win = 0, stall = 0, busy_cycles = 0;
  bit          in_fire = 1'b0;
  string       cur_tag = "";
  logic [63:0] wq[$];
  logic [32:0] ehv[$], eid[$];
  bit   [31:0] codes[$];

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  // monitor: observe handshakes between edges, pop and compare
  always @(negedge clk) if (rst_n) begin
    in_fire = s_valid && s_ready;
    if (busy) busy_cycles++;
    if (hv_valid && hv_ready) begin
      if (ehv.size() == 0) begin
        n_chk++; n_bad++;
        $display("FAIL %s R4 extra bitmap beat actual=%0h expected=none", cur_tag, {hv_last, hv_data});
      end else chk({cur_tag, " R4 bitmap"}, 64'({hv_last, hv_data}), 64'(ehv.pop_front()));
    end
    if (id_valid && id_ready) begin
      if (eid.size() == 0) begin
        n_chk++; n_bad++;
        $display("FAIL %s R5 extra id beat actual=%0h expected=none", cur_tag, {id_last, id_data});
      end else chk({cur_tag, " R5/R6 row id"}, 64'({id_last, id_data}), 64'(eid.pop_front()));
    end
  end

  // driver for the input stream and output readies
  always @(posedge clk) begin
    #1;
    if (in_fire) begin
      win++;
      s_valid = 1'b0;
    end
    in_fire = 1'b0;
    if (!s_valid) begin
      if (win < wq.size() && (stall == 0 || ($urandom % 4) != 0)) begin
        s_valid = 1'b1;
        s_data  = wq[win];
      end
    end
    hv_ready = (stall == 0) || (($urandom % 3) != 0);
    id_ready = (stall == 0) || (($urandom % 3) != 0);
  end

  task automatic pulse_start();
    @(posedge clk); #1 start = 1'b1;
    @(posedge clk); #1 start = 1'b0;
  endtask

  // mode: 0 random, 1 ramp, 2 bound probes; poke: restart attempt mid-scan
  task automatic run_scan(string tag, int w, int rows, bit [31:0] lo, bit [31:0] hi,
                          int mode, int stl, bit poke);
    bit [31:0]   m;
    bit [31:0]   v;
    int          nwords;
    logic [31:0] acc;
    int          guard;
    bit          lasthit;
    m = (w == 32) ? 32'hFFFF_FFFF : ((32'd1 << w) - 1);
    codes.delete(); wq.delete(); win = 0;
    for (int r = 0; r < rows; r++) begin
      case (mode)
        0: v = $urandom & m;
        1: v = 32'(r) & m;
        default: case (r % 4) 0: v = lo - 1; 1: v = lo; 2: v = hi - 1; default: v = hi; endcase
      endcase
      codes.push_back(v & m);
    end
    nwords = (rows * w + 63) / 64;
    for (int i = 0; i < nwords; i++) wq.push_back('1);
    for (int r = 0; r < rows; r++)
      for (int b = 0; b < w; b++) wq[(r*w+b)/64][(r*w+b)%64] = codes[r][b];
    acc = '0;
    lasthit = 1'b0;
    for (int r = 0; r < rows; r++) begin
      lasthit = (codes[r] >= lo) && (codes[r] < hi);
      acc[r % 32] = lasthit;
      if (lasthit) eid.push_back({(r == rows - 1), 32'(r + 1)});
      if ((r % 32) == 31 || r == rows - 1) begin
        ehv.push_back({(r == rows - 1), acc});
        acc = '0;
      end
    end
    if (!lasthit) eid.push_back({1'b1, 32'd0});
    cur_tag = tag;
    stall = stl;
    cfg_width = 6'(w); cfg_rows = 32'(rows); cfg_lo = lo; cfg_hi = hi;
    busy_cycles = 0;
    pulse_start();
    if (poke) begin
      repeat (3) @(posedge clk);
      #1 cfg_width = 6'(w == 32 ? 5 : w + 3); cfg_lo = 0; cfg_hi = 32'hFFFF_FFFF;
      pulse_start();
    end
    guard = 0;
    while ((busy || ehv.size() != 0 || eid.size() != 0) && guard < 20000) begin
      @(negedge clk); guard++;
    end
    repeat (3) @(negedge clk);
    chk({tag, " R7 words consumed"}, 64'(win), 64'(nwords));
    chk({tag, " R4 bitmap queue drained"}, 64'(ehv.size()), 64'd0);
    chk({tag, " R6 id queue drained"}, 64'(eid.size()), 64'd0);
    if (stl == 0 && !poke)
      chk({tag, " R11 busy cycles"}, 64'(busy_cycles), 64'(rows + 1));
    ehv.delete(); eid.delete();
  endtask

  task automatic ignored_start(string tag, int w, int rows);
    cur_tag = tag;
    cfg_width = 6'(w); cfg_rows = 32'(rows); cfg_lo = 0; cfg_hi = 32'hFFFF_FFFF;
    pulse_start();
    repeat (4) @(negedge clk);
    chk({tag, " busy stays low"}, 64'(busy), 64'd0);
    chk({tag, " input not accepted"}, 64'(s_ready), 64'd0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    report();
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk("R9 reset busy", 64'(busy), 64'd0);
    chk("R9 reset s_ready", 64'(s_ready), 64'd0);
    chk("R4 reset hv_valid", 64'(hv_valid), 64'd0);
    chk("R5 reset id_valid", 64'(id_valid), 64'd0);

    run_scan("R1 R2 width15 straddle", 15, 64, 32'h1000, 32'h5000, 0, 0, 1'b0);
    run_scan("R1 width8 ramp stalled R10", 8, 40, 5, 20, 1, 1, 1'b0);
    run_scan("R8 width32", 32, 10, 0, 32'hFFFF_FFFF, 0, 0, 1'b0);
    run_scan("R8 width1", 1, 70, 1, 2, 0, 0, 1'b0);
    run_scan("R3 empty range", 12, 33, 7, 7, 0, 0, 1'b0);
    run_scan("R3 inverted range", 9, 20, 300, 10, 1, 1, 1'b0);
    run_scan("R6 final row matches width13", 13, 5, 0, 32'h2000, 1, 0, 1'b0);
    run_scan("R2 bound probes width10", 10, 12, 100, 200, 2, 0, 1'b0);
    run_scan("R8 R9 restart ignored width7", 7, 90, 20, 90, 1, 1, 1'b1);
    run_scan("R7 R10 width15 stalled tail", 15, 37, 32'h0400, 32'h7000, 0, 1, 1'b0);

    ignored_start("R9 zero rows", 8, 0);
    ignored_start("R9 width zero", 0, 10);
    ignored_start("R9 width 33", 33, 10);

    report();
    $finish;
  end
endmodule